// File: doc/BRIEF.md
# Random Access Preamble Timing Generator

This block produces the chip-by-chip timing of a slotted random-access transmitter. A chip-enable strobe advances it one chip at a time. It keeps a chip counter inside each slot and a slot counter across a cycle of two radio frames. One radio frame holds 15 slots of 2560 chips, 38400 chips in all. Every second slot begins an access opportunity, so there are 15 access slots per two frames, spaced 5120 chips apart. A frame-sync pulse realigns the two-frame cycle to its start.

A start request is held pending until the next access-slot boundary whose bit is set in the availability mask. The preamble then begins on that boundary chip. The preamble is a 16-chip signature sent 256 times back to back, 4096 chips in all. The chip of signature s at position k in the repetition is the parity of (s AND k). The message part follows on the very next chip and lasts one frame or two frames. Flags mark the first chip of each message frame and the last message chip.

Scrambling, spreading and pulse shaping are handled by the blocks around this one. The counters are exported so those blocks can align to the same chip grid.

Top module: `rap_preamble_timer`

## Requirements
- R1: Counters move only on cycles where `chip_en` is high. `chip_num` runs 0..SLOT_CHIPS-1. At each wrap `slot_num` advances through 0..14. `frame_odd` is high during the second frame of the two-frame cycle.
- R2: `frame_sync` together with `chip_en` makes the next chip chip 0 of slot 0 of the even frame. Without `chip_en`, `frame_sync` has no effect.
- R3: `acc_slot` gives the access slot that holds the current chip. Access slot i covers global slots 2i and 2i+1, and starts at chip i*5120 of the two-frame cycle.
- R4: A request is accepted only while the block is idle and nothing is pending. On acceptance, `req_pending` rises on the next clock and `sig_idx` and `msg_two` are captured. Further requests while pending change nothing.
- R5: A pending preamble starts only on the first chip of access slot i, and only when `slot_mask[i]` is 1 on that chip's enabling edge. While the mask is all zero, a pending request is never served.
- R6: The preamble lasts SIG_LEN*SIG_REPS chips (4096). At preamble chip n, `pre_chip` equals the XOR of the bits of `sig AND (n mod 16)`. `pre_chip` is 0 outside the preamble.
- R7: The message starts on the chip right after the last preamble chip. It lasts one frame when the captured `msg_two` was 0, and two frames when it was 1.
- R8: `msg_frame_start` is high on the first chip of each message frame: message chip 0, and also message chip FRAME_CHIPS in a two-frame message.
- R9: `msg_end` is high on the last message chip. The next chip is idle.
- R10: `busy` is high from the first preamble chip to the last message chip. Requests that arrive while busy are ignored.
- R11: After reset all counters are zero, the block is idle, nothing is pending and every flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Advances one chip when high |
| frame_sync | input | 1 | Realigns the next chip to the start of the two-frame cycle |
| start_req | input | 1 | Request for a random-access transmission |
| slot_mask | input | N_ACC (15) | Bit i enables access slot i |
| sig_idx | input | SIG_W (4) | Signature index |
| msg_two | input | 1 | 1 = two-frame message, 0 = one frame |
| pre_chip | output | 1 | Preamble chip value |
| pre_active | output | 1 | Current chip belongs to the preamble |
| msg_active | output | 1 | Current chip belongs to the message |
| msg_frame_start | output | 1 | First chip of a message frame |
| msg_end | output | 1 | Last message chip |
| busy | output | 1 | Transmission in progress |
| req_pending | output | 1 | Request waiting for an access slot |
| chip_num | output | CHIP_W (12) | Chip index inside the slot |
| slot_num | output | SLOT_W (4) | Slot index inside the frame |
| frame_odd | output | 1 | Second frame of the two-frame cycle |
| acc_slot | output | ACC_W (4) | Access slot holding the current chip |

## Verification
A wrong slot or chip counter shows at the ports on the very next enabled chip, because the bench compares the counters every clock. A wrong start condition shows up as a preamble at the wrong chip. That error is seen on the first chip of the misplaced access slot, or, when a start is missed, at the expected start chip. A wrong phase counter gives a preamble or message edge that is off by one or more chips. Such an error appears at the first boundary where the reference model and the design disagree. A wrong signature bit shows in `pre_chip` within the first 16 preamble chips.

// File: rtl/rap_pkg.sv
package rap_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_MSG  = 2'd2
   } rap_phase_e;
endpackage

// File: rtl/rap_timebase.sv
// Chip and slot counters over a two-frame cycle, plus look-ahead of the
// next chip position used to decide access-slot starts.
module rap_timebase #(
   parameter int SLOT_CHIPS      = 2560,
   parameter int SLOTS_PER_FRAME = 15,
   parameter int ACC_STRIDE      = 2,
   localparam int CHIP_W = $clog2(SLOT_CHIPS),
   localparam int GS_W   = $clog2(2 * SLOTS_PER_FRAME),
   localparam int SLOT_W = $clog2(SLOTS_PER_FRAME),
   localparam int N_ACC  = (2 * SLOTS_PER_FRAME) / ACC_STRIDE,
   localparam int ACC_W  = $clog2(N_ACC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              frame_sync,
   output logic [CHIP_W-1:0] chip_q,
   output logic [SLOT_W-1:0] slot_in_frame,
   output logic              frame_odd,
   output logic [ACC_W-1:0]  cur_acc,
   output logic              nxt_edge,
   output logic [ACC_W-1:0]  nxt_acc
);
   localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(SLOT_CHIPS - 1);
   localparam logic [GS_W-1:0]   LAST_GS   = GS_W'(2 * SLOTS_PER_FRAME - 1);
   localparam logic [GS_W-1:0]   SPF_G     = GS_W'(SLOTS_PER_FRAME);

   logic [GS_W-1:0]   gslot_q;
   logic [CHIP_W-1:0] nxt_chip;
   logic [GS_W-1:0]   nxt_gs;

   always_comb begin
      nxt_chip = chip_q + 1'b1;
      nxt_gs   = gslot_q;
      if (frame_sync) begin
         nxt_chip = '0;
         nxt_gs   = '0;
      end else if (chip_q == LAST_CHIP) begin
         nxt_chip = '0;
         nxt_gs   = (gslot_q == LAST_GS) ? '0 : gslot_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chip_q  <= '0;
         gslot_q <= '0;
      end else if (chip_en) begin
         chip_q  <= nxt_chip;
         gslot_q <= nxt_gs;
      end
   end

   assign frame_odd     = (gslot_q >= SPF_G);
   assign slot_in_frame = SLOT_W'(frame_odd ? gslot_q - SPF_G : gslot_q);

   generate
      if (ACC_STRIDE == 1) begin : g_unit
         assign nxt_edge = (nxt_chip == '0);
         assign nxt_acc  = ACC_W'(nxt_gs);
         assign cur_acc  = ACC_W'(gslot_q);
      end else begin : g_stride
         localparam logic [GS_W-1:0] STR = GS_W'(ACC_STRIDE);
         assign nxt_edge = (nxt_chip == '0) && ((nxt_gs % STR) == '0);
         assign nxt_acc  = ACC_W'(nxt_gs / STR);
         assign cur_acc  = ACC_W'(gslot_q / STR);
      end
   endgenerate
endmodule

// File: rtl/rap_slot_gate.sv
// Holds an accepted request and fires a start on an enabled access slot.
module rap_slot_gate #(
   parameter int N_ACC   = 15,
   parameter int SIG_LEN = 16,
   localparam int ACC_W = $clog2(N_ACC),
   localparam int SIG_W = $clog2(SIG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             start_req,
   input  logic             idle,
   input  logic             nxt_edge,
   input  logic [ACC_W-1:0] nxt_acc,
   input  logic [N_ACC-1:0] slot_mask,
   input  logic [SIG_W-1:0] sig_idx,
   input  logic             msg_two,
   output logic             pending_q,
   output logic [SIG_W-1:0] sig_q,
   output logic             two_q,
   output logic             go
);
   assign go = chip_en & pending_q & idle & nxt_edge & slot_mask[nxt_acc];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         sig_q     <= '0;
         two_q     <= 1'b0;
      end else if (go) begin
         pending_q <= 1'b0;
      end else if (start_req && idle && !pending_q) begin
         pending_q <= 1'b1;
         sig_q     <= sig_idx;
         two_q     <= msg_two;
      end
   end
endmodule

// File: rtl/rap_sequencer.sv
// Phase machine: idle, preamble, message, with one shared chip counter.
module rap_sequencer
   import rap_pkg::*;
#(
   parameter int PRE_LEN     = 4096,
   parameter int FRAME_CHIPS = 38400,
   parameter int SIG_LEN     = 16,
   localparam int MAXC  = (2 * FRAME_CHIPS > PRE_LEN) ? 2 * FRAME_CHIPS : PRE_LEN,
   localparam int CNT_W = $clog2(MAXC),
   localparam int SIG_W = $clog2(SIG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_en,
   input  logic             go,
   input  logic             two_q,
   output logic             pre_active,
   output logic             msg_active,
   output logic             msg_frame_start,
   output logic             msg_end,
   output logic [SIG_W-1:0] sig_pos
);
   localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
   localparam logic [CNT_W-1:0] ONE_LAST   = CNT_W'(FRAME_CHIPS - 1);
   localparam logic [CNT_W-1:0] TWO_LAST   = CNT_W'(2 * FRAME_CHIPS - 1);
   localparam logic [CNT_W-1:0] FRAME_MARK = CNT_W'(FRAME_CHIPS);

   rap_phase_e       ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] msg_last;

   assign msg_last = two_q ? TWO_LAST : ONE_LAST;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      if (chip_en) begin
         unique case (ph_q)
            PH_IDLE: if (go) begin
               ph_d  = PH_PRE;
               cnt_d = '0;
            end
            PH_PRE: if (cnt_q == PRE_LAST) begin
               ph_d  = PH_MSG;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
            PH_MSG: if (cnt_q == msg_last) begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
            default: begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign pre_active      = (ph_q == PH_PRE);
   assign msg_active      = (ph_q == PH_MSG);
   assign msg_frame_start = msg_active && ((cnt_q == '0) || (two_q && cnt_q == FRAME_MARK));
   assign msg_end         = msg_active && (cnt_q == msg_last);
   assign sig_pos         = cnt_q[SIG_W-1:0];
endmodule

// File: rtl/rap_sig_chip.sv
// Signature chip: parity of signature index ANDed with chip position.
module rap_sig_chip #(
   parameter int SIG_LEN = 16,
   localparam int SIG_W = $clog2(SIG_LEN)
) (
   input  logic             en,
   input  logic [SIG_W-1:0] sig,
   input  logic [SIG_W-1:0] pos,
   output logic             chip
);
   logic [SIG_W-1:0] hit;

   generate
      for (genvar b = 0; b < SIG_W; b++) begin : g_bit
         assign hit[b] = sig[b] & pos[b];
      end
   endgenerate

   assign chip = en & (^hit);
endmodule

// File: rtl/rap_preamble_timer.sv
module rap_preamble_timer #(
   parameter int SLOT_CHIPS      = 2560,
   parameter int SLOTS_PER_FRAME = 15,
   parameter int ACC_STRIDE      = 2,
   parameter int SIG_LEN         = 16,
   parameter int SIG_REPS        = 256,
   localparam int FRAME_CHIPS = SLOT_CHIPS * SLOTS_PER_FRAME,
   localparam int PRE_LEN     = SIG_LEN * SIG_REPS,
   localparam int N_ACC       = (2 * SLOTS_PER_FRAME) / ACC_STRIDE,
   localparam int CHIP_W      = $clog2(SLOT_CHIPS),
   localparam int SLOT_W      = $clog2(SLOTS_PER_FRAME),
   localparam int ACC_W       = $clog2(N_ACC),
   localparam int SIG_W       = $clog2(SIG_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              frame_sync,
   input  logic              start_req,
   input  logic [N_ACC-1:0]  slot_mask,
   input  logic [SIG_W-1:0]  sig_idx,
   input  logic              msg_two,
   output logic              pre_chip,
   output logic              pre_active,
   output logic              msg_active,
   output logic              msg_frame_start,
   output logic              msg_end,
   output logic              busy,
   output logic              req_pending,
   output logic [CHIP_W-1:0] chip_num,
   output logic [SLOT_W-1:0] slot_num,
   output logic              frame_odd,
   output logic [ACC_W-1:0]  acc_slot
);
   initial begin
      if (SLOT_CHIPS < 2)
         $error("rap_preamble_timer: SLOT_CHIPS must be at least 2");
      if (SLOTS_PER_FRAME < 2)
         $error("rap_preamble_timer: SLOTS_PER_FRAME must be at least 2");
      if (ACC_STRIDE < 1 || ((2 * SLOTS_PER_FRAME) % ACC_STRIDE) != 0)
         $error("rap_preamble_timer: ACC_STRIDE must divide the two-frame slot count");
      if (SIG_LEN < 2 || SIG_LEN != (1 << SIG_W))
         $error("rap_preamble_timer: SIG_LEN must be a power of two");
      if (SIG_REPS < 1)
         $error("rap_preamble_timer: SIG_REPS must be positive");
   end

   logic             nxt_edge;
   logic [ACC_W-1:0] nxt_acc;
   logic             go;
   logic [SIG_W-1:0] sig_q;
   logic             two_q;
   logic [SIG_W-1:0] sig_pos;

   rap_timebase #(
      .SLOT_CHIPS     (SLOT_CHIPS),
      .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
      .ACC_STRIDE     (ACC_STRIDE)
   ) u_tb (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_en      (chip_en),
      .frame_sync   (frame_sync),
      .chip_q       (chip_num),
      .slot_in_frame(slot_num),
      .frame_odd    (frame_odd),
      .cur_acc      (acc_slot),
      .nxt_edge     (nxt_edge),
      .nxt_acc      (nxt_acc)
   );

   rap_slot_gate #(
      .N_ACC  (N_ACC),
      .SIG_LEN(SIG_LEN)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .chip_en  (chip_en),
      .start_req(start_req),
      .idle     (~busy),
      .nxt_edge (nxt_edge),
      .nxt_acc  (nxt_acc),
      .slot_mask(slot_mask),
      .sig_idx  (sig_idx),
      .msg_two  (msg_two),
      .pending_q(req_pending),
      .sig_q    (sig_q),
      .two_q    (two_q),
      .go       (go)
   );

   rap_sequencer #(
      .PRE_LEN    (PRE_LEN),
      .FRAME_CHIPS(FRAME_CHIPS),
      .SIG_LEN    (SIG_LEN)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .chip_en        (chip_en),
      .go             (go),
      .two_q          (two_q),
      .pre_active     (pre_active),
      .msg_active     (msg_active),
      .msg_frame_start(msg_frame_start),
      .msg_end        (msg_end),
      .sig_pos        (sig_pos)
   );

   rap_sig_chip #(
      .SIG_LEN(SIG_LEN)
   ) u_sig (
      .en  (pre_active),
      .sig (sig_q),
      .pos (sig_pos),
      .chip(pre_chip)
   );

   assign busy = pre_active | msg_active;
endmodule

// File: rtl/rap_preamble_timer_chk.sv
module rap_preamble_timer_chk #(
   parameter int SLOT_CHIPS      = 2560,
   parameter int SLOTS_PER_FRAME = 15,
   parameter int ACC_STRIDE      = 2,
   localparam int N_ACC  = (2 * SLOTS_PER_FRAME) / ACC_STRIDE,
   localparam int CHIP_W = $clog2(SLOT_CHIPS),
   localparam int SLOT_W = $clog2(SLOTS_PER_FRAME),
   localparam int ACC_W  = $clog2(N_ACC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              frame_sync,
   input logic [N_ACC-1:0]  slot_mask,
   input logic              pre_chip,
   input logic              pre_active,
   input logic              msg_end,
   input logic              busy,
   input logic              req_pending,
   input logic [CHIP_W-1:0] chip_num,
   input logic [SLOT_W-1:0] slot_num,
   input logic              frame_odd,
   input logic [ACC_W-1:0]  acc_slot
);
   logic [N_ACC-1:0] mask_d;
   int               gsi;

   always_ff @(posedge clk) mask_d <= slot_mask;

   always_comb gsi = frame_odd ? 32'(slot_num) + SLOTS_PER_FRAME : 32'(slot_num);

   // R1
   chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> $stable(chip_num) && $stable(slot_num) && $stable(frame_odd));

   // R2
   sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en && frame_sync |=> (chip_num == '0) && (slot_num == '0) && !frame_odd);

   // R5
   start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre_active) |-> (chip_num == '0) && ((gsi % ACC_STRIDE) == 0) && mask_d[acc_slot]);

   // R6
   pre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_active |-> !pre_chip);

   // R9
   end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end && chip_en |=> !busy);

   // R10
   busy_nopend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_pending);
endmodule

bind rap_preamble_timer rap_preamble_timer_chk #(
   .SLOT_CHIPS     (SLOT_CHIPS),
   .SLOTS_PER_FRAME(SLOTS_PER_FRAME),
   .ACC_STRIDE     (ACC_STRIDE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_en    (chip_en),
   .frame_sync (frame_sync),
   .slot_mask  (slot_mask),
   .pre_chip   (pre_chip),
   .pre_active (pre_active),
   .msg_end    (msg_end),
   .busy       (busy),
   .req_pending(req_pending),
   .chip_num   (chip_num),
   .slot_num   (slot_num),
   .frame_odd  (frame_odd),
   .acc_slot   (acc_slot)
);

// File: tb/sim_rap_preamble_timer.sv
module sim_rap_preamble_timer;
   localparam int SLOT  = 8;
   localparam int SPF   = 15;
   localparam int FRAME = SLOT * SPF;
   localparam int CYC   = 2 * FRAME;
   localparam int PRE   = 64;
   localparam int ASP   = 2 * SLOT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en = 1'b0;
   logic        frame_sync = 1'b0;
   logic        start_req = 1'b0;
   logic [14:0] slot_mask = '0;
   logic [3:0]  sig_idx = '0;
   logic        msg_two = 1'b0;
   logic        pre_chip, pre_active, msg_active, msg_frame_start, msg_end;
   logic        busy, req_pending, frame_odd;
   logic [2:0]  chip_num;
   logic [3:0]  slot_num, acc_slot;

   int n_chk = 0, n_fail = 0, cyc = 0, ce_mode = 0;
   int mchips = 0, mfs = 0, pchips = 0;
   bit done = 0;
   logic [7:0] lfsr = 8'h5a;

   rap_preamble_timer #(
      .SLOT_CHIPS(SLOT), .SLOTS_PER_FRAME(SPF), .ACC_STRIDE(2),
      .SIG_LEN(16), .SIG_REPS(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .frame_sync(frame_sync),
      .start_req(start_req), .slot_mask(slot_mask), .sig_idx(sig_idx),
      .msg_two(msg_two), .pre_chip(pre_chip), .pre_active(pre_active),
      .msg_active(msg_active), .msg_frame_start(msg_frame_start),
      .msg_end(msg_end), .busy(busy), .req_pending(req_pending),
      .chip_num(chip_num), .slot_num(slot_num), .frame_odd(frame_odd),
      .acc_slot(acc_slot)
   );

   always #4 clk = ~clk;

   // chip-enable patterns: off, every clock, alternate, pseudo-random
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ce_mode)
         0: chip_en = 1'b0;
         1: chip_en = 1'b1;
         2: chip_en = ~chip_en;
         default: chip_en = lfsr[0] | lfsr[2];
      endcase
   end

   // behavioural reference model
   int m_pos, m_pend, m_sig, m_two, m_ph, m_cnt;
   always @(posedge clk) begin
      int o_pend, o_ph, np;
      bit g;
      if (!rst_n) begin
         m_pos = 0; m_pend = 0; m_sig = 0; m_two = 0; m_ph = 0; m_cnt = 0;
      end else begin
         o_pend = m_pend;
         o_ph   = m_ph;
         if (chip_en) begin
            np = frame_sync ? 0 : (m_pos + 1) % CYC;
            g  = (o_ph == 0) && (o_pend != 0) && (np % ASP == 0) && slot_mask[np / ASP];
            if (m_ph == 0) begin
               if (g) begin m_ph = 1; m_cnt = 0; m_pend = 0; end
            end else if (m_ph == 1) begin
               if (m_cnt == PRE - 1) begin m_ph = 2; m_cnt = 0; end
               else m_cnt++;
            end else begin
               if (m_cnt == (m_two ? 2 : 1) * FRAME - 1) begin m_ph = 0; m_cnt = 0; end
               else m_cnt++;
            end
            m_pos = np;
         end
         if (start_req && o_ph == 0 && o_pend == 0) begin
            m_pend = 1; m_sig = int'(sig_idx); m_two = int'(msg_two);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   // compare against the model every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [3:0] t;
         int gs, len;
         gs  = m_pos / SLOT;
         len = (m_two ? 2 : 1) * FRAME;
         t   = 4'(m_sig) & 4'(m_cnt % 16);
         chk("R1 chip_num", int'(chip_num), m_pos % SLOT);
         chk("R1 slot_num", int'(slot_num), gs % SPF);
         chk("R1 frame_odd", int'(frame_odd), int'(gs >= SPF));
         chk("R3 acc_slot", int'(acc_slot), gs / 2);
         chk("R4 req_pending", int'(req_pending), m_pend);
         chk("R6 pre_active", int'(pre_active), int'(m_ph == 1));
         chk("R6 pre_chip", int'(pre_chip), (m_ph == 1) ? int'(^t) : 0);
         chk("R7 msg_active", int'(msg_active), int'(m_ph == 2));
         chk("R8 msg_frame_start", int'(msg_frame_start), int'(m_ph == 2 && (m_cnt % FRAME) == 0));
         chk("R9 msg_end", int'(msg_end), int'(m_ph == 2 && m_cnt == len - 1));
         chk("R10 busy", int'(busy), int'(m_ph != 0));
         if (msg_active && chip_en) mchips++;
         if (msg_frame_start && chip_en) mfs++;
         if (pre_active && chip_en) pchips++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic pulse_req();
      @(posedge clk); #1 start_req = 1'b1;
      @(posedge clk); #1 start_req = 1'b0;
   endtask

   task automatic wait_busy(input bit v);
      for (int n = 0; n < 20000 && busy !== v; n++) @(negedge clk);
   endtask

   task automatic clear_counts();
      mchips = 0; mfs = 0; pchips = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", int'(busy), 0);
      chk("R11 chip_num", int'(chip_num), 0);
      chk("R11 slot_num", int'(slot_num), 0);
      chk("R11 req_pending", int'(req_pending), 0);
      chk("R11 flags", int'(pre_chip | msg_end | msg_frame_start | frame_odd), 0);

      ce_mode = 1;
      repeat (37) @(posedge clk);
      // R2 frame sync realigns
      #1 frame_sync = 1'b1;
      @(posedge clk); #1 frame_sync = 1'b0;
      @(negedge clk);
      chk("R2 chip after sync", int'(chip_num), 0);
      chk("R2 slot after sync", int'(slot_num), 0);
      chk("R2 even frame", int'(frame_odd), 0);

      // Scenario A: single enabled access slot, one-frame message
      clear_counts();
      slot_mask = 15'h0008; sig_idx = 4'd5; msg_two = 1'b0;
      pulse_req();
      @(negedge clk);
      chk("R4 pending after request", int'(req_pending), 1);
      sig_idx = 4'd9;
      pulse_req();  // R4 second request while pending is ignored
      wait_busy(1'b1);
      chk("R5 start access slot", int'(acc_slot), 3);
      chk("R5 start chip", int'(chip_num), 0);
      chk("R3 start slot", int'(slot_num), 6);
      slot_mask = 15'h7fff;
      pulse_req();
      @(negedge clk);
      chk("R10 request ignored while busy", int'(req_pending), 0);
      wait_busy(1'b0);
      chk("R6 preamble chips", pchips, PRE);
      chk("R7 one-frame message chips", mchips, FRAME);
      chk("R8 one-frame starts", mfs, 1);

      // Scenario B: zero mask never served, then two-frame message, slow chips
      clear_counts();
      slot_mask = '0; sig_idx = 4'd2; msg_two = 1'b1;
      pulse_req();
      repeat (600) @(posedge clk);
      @(negedge clk);
      chk("R5 zero mask no start", int'(busy), 0);
      chk("R5 zero mask still pending", int'(req_pending), 1);
      ce_mode = 2;
      slot_mask = 15'h4000;
      wait_busy(1'b1);
      chk("R5 last access slot", int'(acc_slot), 14);
      chk("R5 last slot odd frame", int'(frame_odd), 1);
      wait_busy(1'b0);
      chk("R7 two-frame message chips", mchips, 2 * FRAME);
      chk("R8 two-frame starts", mfs, 2);

      // Scenario C: all slots enabled, sync during preamble, full signature
      clear_counts();
      ce_mode = 1;
      slot_mask = 15'h7fff; sig_idx = 4'd15; msg_two = 1'b0;
      pulse_req();
      wait_busy(1'b1);
      repeat (10) @(posedge clk);
      #1 frame_sync = 1'b1;
      @(posedge clk); #1 frame_sync = 1'b0;
      wait_busy(1'b0);
      chk("R6 preamble chips with sync", pchips, PRE);

      // Scenario D: irregular chip enable, odd access slots only
      clear_counts();
      ce_mode = 3;
      slot_mask = 15'h2aaa; sig_idx = 4'd6; msg_two = 1'b1;
      pulse_req();
      wait_busy(1'b1);
      chk("R5 odd access slot", int'(acc_slot) % 2, 1);
      wait_busy(1'b0);
      chk("R9 back to idle", int'(busy), 0);
      chk("R7 irregular message chips", mchips, 2 * FRAME);

      ce_mode = 0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      done = 1;
      finish_run();
   end
endmodule